// File: doc/BRIEF.md
# Conversion Start Sequencer

This block holds the control core of a 16-bit successive-approximation converter. A conversion is launched by a high-to-low transition on an active-low start pin. The pin is first passed through a synchronizer, and only the transition counts, never the low level. Once launched, a conversion runs for a fixed number of clock cycles, measured by one internal down-counter. The busy flag stays high for that whole window. When the window closes, the value on a stand-in sample port is stored in a result register, and a single-cycle done strobe fires.

After every conversion, and after every reset, the block enforces a hold-off window for acquisition. Start transitions that arrive during a conversion or during the hold-off are discarded; they are not saved for later. A high level on the reset input stops any conversion in progress and blanks the output bus. The result is a held register with a drive-enable flag and no back-pressure. A consumer takes it on the done strobe or at any later time, until the next done strobe replaces it.

Top module: `adc_conv_sequencer`

## Requirements
- R1: While `rst` is high (sampled on the clock edge), every following cycle shows `busy` = 0, `done` = 0, `result_oe` = 0 and `result` = 0.
- R2: When the block is idle, a 1-to-0 transition on `start_n` raises `busy` on the third rising clock edge after the new level is first sampled: two synchronizer stages, then the edge register. Keeping `start_n` low starts no further conversions.
- R3: `busy` stays high for exactly `CONV_CYCLES` consecutive cycles for each conversion that no reset interrupts.
- R4: `done` is high for exactly one cycle, and that cycle is the first one in which `busy` is low after a completed conversion. In the same cycle, `result` equals the `sample_in` value present during the last busy cycle, and `result_oe` goes to 1.
- R5: Start transitions that arrive while `busy` is high neither restart nor extend the running conversion.
- R6: After a conversion ends, start transitions seen in the following `ACQ_CYCLES` cycles are dropped and never start a conversion later.
- R7: A reset during a conversion drops `busy` and `result_oe` to 0 with no `done` pulse.
- R8: After `rst` falls, start transitions are refused for `ACQ_CYCLES` cycles.
- R9: `result` holds its value in every cycle that has no `done` pulse and no reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset and abort |
| start_n | input | 1 | Asynchronous active-low start; the falling edge launches a conversion |
| sample_in | input | DATA_W | Stand-in converted value, captured when a conversion ends |
| busy | output | 1 | High while a conversion runs |
| done | output | 1 | One-cycle strobe when a result has been latched |
| result | output | DATA_W | Last latched conversion result |
| result_oe | output | 1 | Output bus drive enable; 0 means the bus is released |

## Verification
A wrong phase or counter value shows up on `busy` within one conversion or one hold-off window. A conversion that runs too long or too short moves the falling edge of `busy` and the `done` strobe to the wrong cycle. A hold-off that ends early lets a start transition rise `busy` one or more cycles before it should. A capture that is lost or happens at the wrong time appears on `result` in the same cycle as `done`. A reference model advances every cycle and compares all four outputs in every cycle, so any divergence is reported in the cycle where it first reaches a port.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CONV = 2'd1,
    PH_HOLD = 2'd2
  } seq_phase_t;

endpackage

// File: rtl/adc_start_sync.sv
module adc_start_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start_n,
  output logic start_fall
);

  logic [STAGES-1:0] chain;
  logic              last_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b1;
          else     chain[0] <= start_n;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b1;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b1;
    else     last_q <= chain[STAGES-1];
  end

  assign start_fall = last_q & ~chain[STAGES-1];

endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (load)              cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 130,
  parameter int ACQ_CYCLES  = 69,
  parameter int CNT_W       = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_fall,
  input  logic              expired,
  input  logic [DATA_W-1:0] sample_in,
  output logic              load,
  output logic [CNT_W-1:0]  load_val,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result,
  output logic              result_oe
);

  localparam logic [CNT_W-1:0] CONV_LOAD = CNT_W'(CONV_CYCLES - 1);
  localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(ACQ_CYCLES - 1);

  seq_phase_t phase_q;
  logic       launch;
  logic       finish;

  assign launch = (phase_q == PH_IDLE) && start_fall;
  assign finish = (phase_q == PH_CONV) && expired;

  always_comb begin
    load     = 1'b0;
    load_val = HOLD_LOAD;
    if (rst) begin
      load = 1'b1;
    end else if (launch) begin
      load     = 1'b1;
      load_val = CONV_LOAD;
    end else if (finish) begin
      load = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_HOLD;
      busy      <= 1'b0;
      done      <= 1'b0;
      result    <= '0;
      result_oe <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (start_fall) begin
            phase_q <= PH_CONV;
            busy    <= 1'b1;
          end
        end
        PH_CONV: begin
          if (expired) begin
            phase_q   <= PH_HOLD;
            busy      <= 1'b0;
            done      <= 1'b1;
            result    <= sample_in;
            result_oe <= 1'b1;
          end
        end
        PH_HOLD: begin
          if (expired) phase_q <= PH_IDLE;
        end
        default: phase_q <= PH_HOLD;
      endcase
    end
  end

endmodule

// File: rtl/adc_conv_sequencer.sv
module adc_conv_sequencer #(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 130,
  parameter int ACQ_CYCLES  = 69,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_n,
  input  logic [DATA_W-1:0] sample_in,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result,
  output logic              result_oe
);

  localparam int MAX_LEN = (CONV_CYCLES > ACQ_CYCLES) ? CONV_CYCLES : ACQ_CYCLES;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  logic             start_fall;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;

  adc_start_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst        (rst),
    .start_n    (start_n),
    .start_fall (start_fall)
  );

  adc_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  adc_seq_ctrl #(
    .DATA_W      (DATA_W),
    .CONV_CYCLES (CONV_CYCLES),
    .ACQ_CYCLES  (ACQ_CYCLES),
    .CNT_W       (CNT_W)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start_fall (start_fall),
    .expired    (tmr_expired),
    .sample_in  (sample_in),
    .load       (tmr_load),
    .load_val   (tmr_val),
    .busy       (busy),
    .done       (done),
    .result     (result),
    .result_oe  (result_oe)
  );

endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker #(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 130,
  parameter int ACQ_CYCLES  = 69
) (
  input logic              clk,
  input logic              rst,
  input logic              start_fall,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] result,
  input logic              result_oe
);

  int unsigned run_len;
  int unsigned quiet_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_len   <= 0;
      quiet_len <= 0;
    end else begin
      run_len   <= busy ? run_len + 1 : 0;
      if (busy)                    quiet_len <= 0;
      else if (quiet_len < 32'hFFFF) quiet_len <= quiet_len + 1;
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!busy && !done && !result_oe && result == '0));

  a_r2_busy_from_edge: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start_fall));

  a_r3_conv_length: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(rst)) |-> run_len == CONV_CYCLES);

  a_r4_done_on_fall: assert property (@(posedge clk) disable iff (rst)
    done |-> ($fell(busy) && result_oe));

  a_r4_fall_gives_done: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(rst)) |-> done);

  a_r6_holdoff_gap: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> quiet_len > ACQ_CYCLES);

  a_r7_abort_no_done: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !done);

  a_r9_result_held: assert property (@(posedge clk) disable iff (rst)
    (!done && !$past(rst)) |-> $stable(result));

endmodule

bind adc_conv_sequencer adc_seq_checker #(
  .DATA_W      (DATA_W),
  .CONV_CYCLES (CONV_CYCLES),
  .ACQ_CYCLES  (ACQ_CYCLES)
) u_seq_checker (
  .clk        (clk),
  .rst        (rst),
  .start_fall (start_fall),
  .busy       (busy),
  .done       (done),
  .result     (result),
  .result_oe  (result_oe)
);

// File: tb/tb_adc_conv_sequencer.sv
module tb_adc_conv_sequencer;

  localparam int DW   = 16;
  localparam int CONV = 13;
  localparam int ACQ  = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_n = 1'b1;
  logic [DW-1:0] sample_in = '0;
  logic          busy, done, result_oe;
  logic [DW-1:0] result;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;
  string scen  = "R1 reset";

  always #4 clk = ~clk;

  adc_conv_sequencer #(
    .DATA_W(DW), .CONV_CYCLES(CONV), .ACQ_CYCLES(ACQ), .SYNC_STAGES(2)
  ) dut (
    .clk(clk), .rst(rst), .start_n(start_n), .sample_in(sample_in),
    .busy(busy), .done(done), .result(result), .result_oe(result_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s [%s] actual=%0h expected=%0h at %0t", req, scen, act, exp, $time);
    end
  endtask

  // Behavioural reference: sync pipe as a small queue, phase as an integer.
  int      pipe[$] = '{1, 1, 1};
  int      phase = 2;  // 0 idle, 1 converting, 2 holding off
  int      left  = ACQ;
  bit      e_busy = 0, e_done = 0, e_oe = 0;
  int      e_res = 0;
  bit      model_live = 0;

  always @(posedge clk) begin
    bit edge_seen;
    edge_seen = (pipe[2] == 1) && (pipe[1] == 0);
    model_live = 1;
    if (rst) begin
      pipe = '{1, 1, 1};
      phase = 2; left = ACQ;
      e_busy = 0; e_done = 0; e_oe = 0; e_res = 0;
    end else begin
      pipe.push_front(int'(start_n));
      void'(pipe.pop_back());
      e_done = 0;
      if (phase == 2) begin
        left--;
        if (left == 0) phase = 0;
      end else if (phase == 0) begin
        if (edge_seen) begin phase = 1; left = CONV; e_busy = 1; end
      end else begin
        left--;
        if (left == 0) begin
          phase = 2; left = ACQ;
          e_busy = 0; e_done = 1; e_oe = 1; e_res = int'(sample_in);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (model_live && !finished) begin
      check("R3 busy",   32'(busy),      32'(e_busy));
      check("R4 done",   32'(done),      32'(e_done));
      check("R9 result", 32'(result),    32'(e_res));
      check("R1 oe",     32'(result_oe), 32'(e_oe));
    end
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input int low_cycles);
    start_n = 1'b0;
    cycles(low_cycles);
    start_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    cycles(4);
    check("R1", 32'({busy, done, result_oe}), 32'd0);
    check("R1", 32'(result), 32'd0);

    scen = "R8 start during post-reset hold-off";
    rst = 1'b0;
    pulse(2);
    cycles(ACQ + 6);
    check("R8", 32'(busy), 32'd0);

    scen = "R2 R3 R4 first conversion";
    sample_in = 16'hA5C3;
    pulse(2);
    cycles(3);
    check("R2", 32'(busy), 32'd1);
    cycles(CONV + 2);
    check("R4", 32'(result), 32'hA5C3);

    scen = "R5 edges during busy";
    cycles(ACQ + 2);
    sample_in = 16'h0F0F;
    pulse(1);
    cycles(5);
    pulse(1); cycles(2); pulse(1);
    sample_in = 16'h1234;
    cycles(CONV);

    scen = "R6 edge right after conversion";
    pulse(1);
    cycles(ACQ + 8);
    check("R6", 32'(busy), 32'd0);

    scen = "R2 held low level";
    sample_in = 16'h8001;
    start_n = 1'b0;
    cycles(CONV + ACQ + 20);
    check("R2", 32'(busy), 32'd0);
    start_n = 1'b1;
    cycles(4);

    scen = "R7 reset during conversion";
    pulse(1);
    cycles(8);
    rst = 1'b1;
    cycles(2);
    check("R7", 32'({busy, result_oe}), 32'd0);
    rst = 1'b0;
    pulse(1);
    cycles(ACQ + 4);
    check("R8", 32'(busy), 32'd0);

    scen = "R9 back-to-back conversions";
    for (int k = 0; k < 3; k++) begin
      sample_in = 16'(16'h4000 + k * 16'h0111);
      pulse(1);
      cycles(CONV + ACQ + 6);
      check("R9", 32'(result), 32'(16'h4000 + k * 16'h0111));
    end

    cycles(5);
    finish_run();
  end

  initial begin
    #(8 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

endmodule